// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block runs the modem-line handshake for one serial channel without software involvement. On the receive side it watches the fill level of the receive FIFO and drives the active-low request-to-send line. When the FIFO fills up to a high mark, the line is released (driven HIGH). Once the FIFO has drained below a low mark, the line is asserted again (driven LOW). A 2-bit hysteresis code places both marks relative to the programmed trigger level. When automatic control is switched off, the line simply follows a software request bit.

On the transmit side the active-low clear-to-send input is brought through a synchronizer and turned into a transmit-allowed signal. That signal is frozen while the transmitter is shifting a character, so the far end can only stop transmission between characters. Sticky change flags for both lines, a trigger-reached flag and a combined interrupt are provided. A read of the modem status clears the change flags.

Top module: `uart_hwflow`

## Requirements
- R1: With `rts_auto_en` low, `rts_n` is the inverse of `rts_req` as sampled at the previous clock edge.
- R2: During and right after reset, `rts_n` is 1, `rts_chg` and `cts_chg` are 0 and `trig_hit` is 0.
- R3: With `rts_auto_en` high, `rts_n` is 1 one cycle after `rx_level` is at or above the high mark. The high mark is computed from the trigger level plus an offset and is never above DEPTH (64). The offset is 8 for `hyst_sel`=0, 4 for `hyst_sel`=1, 6 for `hyst_sel`=2 and 8 for `hyst_sel`=3.
- R4: With `rts_auto_en` high, `rts_n` is 0 one cycle after `rx_level` is below the low mark. The low mark is the trigger level minus 0, 4, 6 or 8 for `hyst_sel` 0, 1, 2 or 3. If that difference is less than 1, the low mark is 1, so the line comes back only when the FIFO is empty.
- R5: With `rts_auto_en` high and `rx_level` between the two marks, `rts_n` keeps its value.
- R6: `trig_hit` shows, one cycle later, whether `rx_level` was at or above `rx_trig`.
- R7: `cts_chg` is set three clock edges after a change of `cts_n` (two synchronizer flops and one edge-detect flop). It is cleared at the edge after `msr_read`, unless a new change is detected at that same edge, in which case it stays set.
- R8: `rts_chg` is set at the same edge at which automatic control drives `rts_n` from 0 to 1. It is cleared at the edge after `msr_read`, unless it is set again at that edge.
- R9: `flow_irq` equals (`cts_chg` AND `cts_auto_en`) OR (`rts_chg` AND `rts_auto_en`).
- R10: With `cts_auto_en` high and `tx_busy` low, `tx_allow` is the inverse of the synchronized `cts_n`. A pin change therefore reaches `tx_allow` two edges later.
- R11: With `cts_auto_en` high, `tx_allow` does not change while `tx_busy` stays high.
- R12: With `cts_auto_en` low, `tx_allow` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | 7 | Receive FIFO fill count, 0 to 64 |
| rx_trig | input | 7 | Programmed receive trigger level, 1 to 64 |
| hyst_sel | input | 2 | Hysteresis code (0 = next trigger step) |
| rts_auto_en | input | 1 | Gives the RTS line to the flow logic |
| rts_req | input | 1 | Software RTS request, used when auto is off |
| cts_auto_en | input | 1 | Lets CTS gate the transmitter |
| cts_n | input | 1 | Asynchronous clear-to-send pin, active low |
| tx_busy | input | 1 | High while a character, up to its stop bit, is being shifted |
| msr_read | input | 1 | One-cycle pulse on a modem status read |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_allow | output | 1 | Transmitter may start a new character |
| trig_hit | output | 1 | Receive FIFO at or above trigger level |
| rts_chg | output | 1 | Sticky: auto control released RTS |
| cts_chg | output | 1 | Sticky: synchronized CTS changed |
| flow_irq | output | 1 | Combined flow-control interrupt |

## Verification
A wrong high or low mark shows at `rts_n` one cycle after the level crosses the mark, as a release that comes too early or too late. A lost hold state shows as `rts_n` toggling while the level sits between the marks. A synchronizer with the wrong depth moves `tx_allow` and `cts_chg` by one cycle away from their expected edges. Randomly timed busy windows catch any leak of the CTS level into a character that is already in flight, in the first busy cycle after the pin has been synchronized. Change flags that are not sticky, or that are cleared with the wrong priority, are visible at `flow_irq` in the cycle after a status read.

// File: rtl/hwflow_pkg.sv
package hwflow_pkg;

  // Offset subtracted from the trigger level for the low mark.
  function automatic int hyst_amount(input logic [1:0] sel, input int h1, input int h2, input int h3);
    case (sel)
      2'd1:    return h1;
      2'd2:    return h2;
      2'd3:    return h3;
      default: return 0;
    endcase
  endfunction

  // Fill level at which RTS# is released.
  function automatic int rts_high_mark(input int trig, input logic [1:0] sel, input int step,
                                       input int depth, input int h1, input int h2, input int h3);
    int m;
    m = (sel == 2'd0) ? trig + step : trig + hyst_amount(sel, h1, h2, h3);
    return (m > depth) ? depth : m;
  endfunction

  // Level below which RTS# is asserted again; never below 1.
  function automatic int rts_low_mark(input int trig, input logic [1:0] sel,
                                      input int h1, input int h2, input int h3);
    int m;
    m = trig - hyst_amount(sel, h1, h2, h3);
    return (m < 1) ? 1 : m;
  endfunction

endpackage

// File: rtl/hwflow_sync.sv
module hwflow_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hwflow_rts.sv
module hwflow_rts
  import hwflow_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int LVL_W     = 7,
  parameter int NEXT_STEP = 8,
  parameter int HYST1     = 4,
  parameter int HYST2     = 6,
  parameter int HYST3     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [1:0]       hyst_sel,
  input  logic             auto_en,
  input  logic             rts_req,
  input  logic             msr_read,
  output logic             rts_n,
  output logic             rts_chg,
  output logic             trig_hit
);
  localparam int MW = LVL_W + 1;

  logic [MW-1:0] hi_mark, lo_mark, lvl_x;
  logic          above_hi, below_lo, rts_next, auto_release;

  assign hi_mark  = MW'(rts_high_mark(int'(rx_trig), hyst_sel, NEXT_STEP, DEPTH, HYST1, HYST2, HYST3));
  assign lo_mark  = MW'(rts_low_mark(int'(rx_trig), hyst_sel, HYST1, HYST2, HYST3));
  assign lvl_x    = {1'b0, rx_level};
  assign above_hi = (lvl_x >= hi_mark);
  assign below_lo = (lvl_x < lo_mark);

  always_comb begin
    if (!auto_en)      rts_next = ~rts_req;
    else if (above_hi) rts_next = 1'b1;
    else if (below_lo) rts_next = 1'b0;
    else               rts_next = rts_n;
  end

  assign auto_release = auto_en && rts_next && !rts_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_n    <= 1'b1;
      rts_chg  <= 1'b0;
      trig_hit <= 1'b0;
    end else begin
      rts_n    <= rts_next;
      trig_hit <= (rx_level >= rx_trig);
      if (auto_release)  rts_chg <= 1'b1;
      else if (msr_read) rts_chg <= 1'b0;
    end
  end

  AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (rts_n == !$past(rts_req)));                              // R1
  AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && above_hi) |=> rts_n);                                     // R3
  AST_RTS_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && below_lo) |=> !rts_n);                                    // R4
  AST_RTS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    auto_release |=> (rts_chg && rts_n));                                 // R8
endmodule

// File: rtl/hwflow_cts.sv
module hwflow_cts #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic auto_en,
  input  logic tx_busy,
  input  logic msr_read,
  output logic tx_allow,
  output logic cts_chg
);
  logic cts_s, cts_prev, cts_edge, held;

  hwflow_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_s)
  );

  assign cts_edge = cts_s ^ cts_prev;
  assign tx_allow = !auto_en ? 1'b1 : (tx_busy ? held : ~cts_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_prev <= 1'b1;
      cts_chg  <= 1'b0;
      held     <= 1'b1;
    end else begin
      cts_prev <= cts_s;
      held     <= tx_allow;
      if (cts_edge)      cts_chg <= 1'b1;
      else if (msr_read) cts_chg <= 1'b0;
    end
  end

  AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && tx_busy && $past(auto_en) && $past(rst_n)) |-> (tx_allow == $past(tx_allow))); // R11
  AST_CTS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_read && !cts_edge) |=> !cts_chg);                                // R7
  AST_CTS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cts_edge |=> cts_chg);                                                // R7
endmodule

// File: rtl/uart_hwflow.sv
module uart_hwflow #(
  parameter int  DEPTH       = 64,
  parameter int  NEXT_STEP   = 8,
  parameter int  HYST1       = 4,
  parameter int  HYST2       = 6,
  parameter int  HYST3       = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [1:0]       hyst_sel,
  input  logic             rts_auto_en,
  input  logic             rts_req,
  input  logic             cts_auto_en,
  input  logic             cts_n,
  input  logic             tx_busy,
  input  logic             msr_read,
  output logic             rts_n,
  output logic             tx_allow,
  output logic             trig_hit,
  output logic             rts_chg,
  output logic             cts_chg,
  output logic             flow_irq
);
  hwflow_rts #(
    .DEPTH(DEPTH), .LVL_W(LVL_W), .NEXT_STEP(NEXT_STEP),
    .HYST1(HYST1), .HYST2(HYST2), .HYST3(HYST3)
  ) u_rts (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_trig(rx_trig),
    .hyst_sel(hyst_sel), .auto_en(rts_auto_en), .rts_req(rts_req),
    .msr_read(msr_read), .rts_n(rts_n), .rts_chg(rts_chg), .trig_hit(trig_hit)
  );

  hwflow_cts #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .auto_en(cts_auto_en),
    .tx_busy(tx_busy), .msr_read(msr_read), .tx_allow(tx_allow), .cts_chg(cts_chg)
  );

  assign flow_irq = (cts_chg & cts_auto_en) | (rts_chg & rts_auto_en);

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    flow_irq |-> ((cts_chg && cts_auto_en) || (rts_chg && rts_auto_en)));   // R9
endmodule

// File: tb/uart_hwflow_test.sv
module uart_hwflow_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rx_level = '0, rx_trig = 7'd16;
  logic [1:0] hyst_sel = '0;
  logic       rts_auto_en = 0, rts_req = 0, cts_auto_en = 0, cts_n = 1, tx_busy = 0, msr_read = 0;
  logic       rts_n, tx_allow, trig_hit, rts_chg, cts_chg, flow_irq;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_hwflow uut (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_trig(rx_trig), .hyst_sel(hyst_sel),
    .rts_auto_en(rts_auto_en), .rts_req(rts_req), .cts_auto_en(cts_auto_en), .cts_n(cts_n),
    .tx_busy(tx_busy), .msr_read(msr_read), .rts_n(rts_n), .tx_allow(tx_allow),
    .trig_hit(trig_hit), .rts_chg(rts_chg), .cts_chg(cts_chg), .flow_irq(flow_irq)
  );

  // Marks as stated in the requirements
  function automatic int hi_of(int trig, int sel);
    int off;
    off = (sel == 1) ? 4 : (sel == 2) ? 6 : 8;
    return (trig + off > 64) ? 64 : trig + off;
  endfunction
  function automatic int lo_of(int trig, int sel);
    int off;
    off = (sel == 0) ? 0 : (sel == 1) ? 4 : (sel == 2) ? 6 : 8;
    return (trig - off < 1) ? 1 : trig - off;
  endfunction

  // Reference state
  bit m_rts = 1, m_rchg = 0, m_trig = 0, m_s1 = 1, m_s2 = 1, m_s3 = 1, m_cchg = 0, m_held = 1;

  function automatic bit exp_allow();
    if (!cts_auto_en) return 1'b1;
    return tx_busy ? m_held : !m_s2;
  endfunction

  always @(posedge clk) begin
    bit nr, nh;
    if (!rst_n) begin
      m_rts = 1; m_rchg = 0; m_trig = 0; m_s1 = 1; m_s2 = 1; m_s3 = 1; m_cchg = 0; m_held = 1;
    end else begin
      nh = exp_allow();
      if (!rts_auto_en) nr = !rts_req;
      else if (int'(rx_level) >= hi_of(int'(rx_trig), int'(hyst_sel))) nr = 1;
      else if (int'(rx_level) < lo_of(int'(rx_trig), int'(hyst_sel))) nr = 0;
      else nr = m_rts;
      if (rts_auto_en && nr && !m_rts) m_rchg = 1;
      else if (msr_read) m_rchg = 0;
      if (m_s2 != m_s3) m_cchg = 1;
      else if (msr_read) m_cchg = 0;
      m_rts = nr;
      m_trig = (rx_level >= rx_trig);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cts_n;
      m_held = nh;
    end
  end

  task automatic check(input string tag, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3 R4 R5 rts_n", rts_n, m_rts);
    check("R6 trig_hit", trig_hit, m_trig);
    check("R7 cts_chg", cts_chg, m_cchg);
    check("R8 rts_chg", rts_chg, m_rchg);
    check("R9 flow_irq", flow_irq, (m_cchg & cts_auto_en) | (m_rchg & rts_auto_en));
    check("R10 R11 R12 tx_allow", tx_allow, exp_allow());
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    msr_read = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 rts_n", rts_n, 1'b1);
    check("R2 rts_chg", rts_chg, 1'b0);
    check("R2 cts_chg", cts_chg, 1'b0);
    check("R2 trig_hit", trig_hit, 1'b0);
    rst_n = 1;
    step();
    check("R2 rts_n after release", rts_n, 1'b1);

    // R1 manual control
    rts_req = 1; step(); check("R1 manual assert", rts_n, 1'b0);
    rts_req = 0; step(); check("R1 manual release", rts_n, 1'b1);
    rts_req = 1; step();

    // R3/R5/R4 with trigger 16, code 1: marks 20 and 12
    rts_auto_en = 1; rx_trig = 16; hyst_sel = 1; rx_level = 5; step();
    rx_level = 19; step(); check("R5 below high mark", rts_n, 1'b0);
    rx_level = 20; step(); check("R3 high mark 20", rts_n, 1'b1); check("R8 set", rts_chg, 1'b1);
    check("R9 irq", flow_irq, 1'b1);
    rx_level = 12; step(); check("R5 hold at low mark", rts_n, 1'b1);
    rx_level = 11; msr_read = 1; step(); check("R4 low mark 12", rts_n, 1'b0);
    check("R8 cleared", rts_chg, 1'b0);

    // Code 0: next step +8; trigger 60 caps at 64
    hyst_sel = 0; rx_trig = 60; rx_level = 63; step(); check("R3 cap not reached", rts_n, 1'b0);
    rx_level = 64; step(); check("R3 capped at 64", rts_n, 1'b1);
    rx_level = 60; step(); check("R5 at trigger", rts_n, 1'b1);
    rx_level = 59; step(); check("R4 below trigger", rts_n, 1'b0);

    // Code 3 with trigger 4: low mark floors at 1
    hyst_sel = 3; rx_trig = 4; rx_level = 12; step(); check("R3 mark 12", rts_n, 1'b1);
    rx_level = 1; step(); check("R4 floor hold", rts_n, 1'b1);
    rx_level = 0; step(); check("R4 empty reasserts", rts_n, 1'b0);

    // CTS path
    cts_auto_en = 1; msr_read = 1; step();
    cts_n = 0; step(); check("R10 one edge", tx_allow, 1'b0);
    step(); check("R10 two edges", tx_allow, 1'b1); check("R7 not yet", cts_chg, 1'b0);
    step(); check("R7 three edges", cts_chg, 1'b1);
    tx_busy = 1; cts_n = 1; step(); step(); step();
    check("R11 frozen in char", tx_allow, 1'b1);
    tx_busy = 0; step(); check("R10 at boundary", tx_allow, 1'b0);
    msr_read = 1; step(); check("R7 cleared", cts_chg, 1'b0);
    cts_auto_en = 0; step(); check("R12 free run", tx_allow, 1'b1);

    // Constrained random
    for (int i = 0; i < 6000; i++) begin
      int d;
      if ($urandom_range(0, 199) == 0) rts_auto_en = ~rts_auto_en;
      if ($urandom_range(0, 249) == 0) cts_auto_en = ~cts_auto_en;
      if ($urandom_range(0, 299) == 0) begin
        rx_trig = 7'($urandom_range(1, 64));
        hyst_sel = 2'($urandom_range(0, 3));
      end
      d = int'(rx_level) + $urandom_range(0, 6) - 3;
      rx_level = 7'((d < 0) ? 0 : (d > 64) ? 64 : d);
      if ($urandom_range(0, 19) == 0) rts_req = ~rts_req;
      if ($urandom_range(0, 11) == 0) cts_n = ~cts_n;
      if ($urandom_range(0, 15) == 0) tx_busy = ~tx_busy;
      msr_read = ($urandom_range(0, 9) == 0);
      step();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule